// File: doc/BRIEF.md
# Pseudorandom RAM Wiper

This block overwrites every word of an on-chip RAM with pseudorandom data after a start pulse. A 32-bit Galois LFSR produces one value per clock. The value has its bits reordered by a fixed wiring permutation and is then driven onto the RAM write port together with an ascending word address. When a pass starts, the LFSR is reloaded from a 32-bit slice of the scrambling nonce currently presented at its input. Each new pass therefore fills the RAM with a different sequence.

While a pass runs, ordinary bus requests are held off. Requests are granted only after a pass has completed. The word address counter exists twice, and the second copy is stored in inverted form. If the two copies ever disagree, the block enters a terminal fault state, stops writing and raises its fatal error output until reset.

Top module: `mem_wiper`

## Requirements
- R1: After reset, `done_o`, `err_o`, `busy_o`, `ram_we_o` and `bus_gnt_o` are all 0.
- R2: A `start_i` pulse seen while idle or done makes `busy_o` and `ram_we_o` high from the next cycle on. Addresses 0, 1, ... MEM_BYTES/4-1 are then written, one per cycle, in ascending order. With the default size this is 1024 words.
- R3: At start, the LFSR is loaded from `nonce_i[SEED_OFS+31:SEED_OFS]`, which is bits 95:64 by default. If that slice is zero, the reset seed 32'h5A3C_96E1 is loaded instead. The first word written comes from the loaded value.
- R4: The LFSR advances exactly once per word written, following next = {1'b0, s[31:1]} ^ (s[0] ? 32'h8020_0003 : 0). Its state is never zero.
- R5: Write data bit i equals LFSR state bit PERM[i]. The default permutation is PERM[i] = (7*i + 3) mod 32.
- R6: In the cycle after the last word is written, `ram_we_o` and `busy_o` drop and `done_o` rises. `done_o` then stays high until the next accepted start, which clears it.
- R7: `bus_gnt_o` equals `bus_req_i` only while `done_o` is high and `err_o` is low. At all other times it is 0, including after reset before any pass.
- R8: A `start_i` pulse during a running pass is ignored. The address and data sequence of that pass continues unchanged.
- R9: A disagreement between the two address counter copies sets `err_o` at the next edge. From then on, `err_o` stays high, no writes occur, `done_o` and `bus_gnt_o` stay 0, and `start_i` is ignored until reset.
- R10: Every accepted start reseeds the LFSR, so a second pass with a different nonce writes the sequence of the new seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a wipe pass |
| nonce_i | input | NONCE_W | Latest scrambling nonce; one slice seeds the LFSR |
| bus_req_i | input | 1 | Ordinary bus access request |
| bus_gnt_o | output | 1 | Grant for the ordinary bus request |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | AddrW | RAM word address |
| ram_wdata_o | output | 32 | Permuted LFSR data |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | Last pass completed |
| err_o | output | 1 | Fatal counter mismatch, terminal |

## Verification
The walk is run with two distinct nonces, so the data sequence is shown to follow the seed and not a fixed pattern. The comparison against a bit-level model separates a wrong tap mask from a wrong permutation. A nonce whose seed slice is zero while other bits are set checks both the fallback seed and the slice position. A start pulse injected mid-walk separates "ignored" from "restarted". Forcing one counter copy mid-walk shows that the fault is caught at once and then stays latched against new starts.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

   localparam int LfsrW   = 32;
   localparam int PermIdxW = $clog2(LfsrW);

   typedef logic [LfsrW-1:0]          lfsr_t;
   typedef logic [LfsrW*PermIdxW-1:0] perm_t;

   typedef enum logic [1:0] {
      WipeIdle = 2'b00,
      WipeRun  = 2'b01,
      WipeDone = 2'b10,
      WipeErr  = 2'b11
   } wipe_state_e;

   // Default output reordering: bit i takes state bit (7*i + 3) mod 32.
   function automatic perm_t default_perm();
      perm_t p;
      p = '0;
      for (int i = 0; i < LfsrW; i++) begin
         p[i*PermIdxW +: PermIdxW] = PermIdxW'((7 * i + 3) % LfsrW);
      end
      return p;
   endfunction

   // A valid permutation touches every source bit exactly once.
   function automatic bit perm_valid(perm_t p);
      logic [LfsrW-1:0] seen;
      seen = '0;
      for (int i = 0; i < LfsrW; i++) begin
         seen[p[i*PermIdxW +: PermIdxW]] = 1'b1;
      end
      return &seen;
   endfunction

   function automatic lfsr_t lfsr_next(lfsr_t s, lfsr_t taps);
      return {1'b0, s[LfsrW-1:1]} ^ (s[0] ? taps : '0);
   endfunction

endpackage

// File: rtl/wiper_ctr.sv
module wiper_ctr #(
   parameter int AW     = 10,
   parameter bit INVERT = 1'b0
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          clr_i,
   input  logic          inc_i,
   output logic [AW-1:0] cnt_o
);

   logic [AW-1:0] cnt_q;
   logic [AW-1:0] count;
   logic [AW-1:0] count_nxt;
   logic [AW-1:0] store_nxt;
   logic [AW-1:0] store_rst;

   generate
      if (INVERT) begin : g_inverted
         assign count     = ~cnt_q;
         assign store_nxt = ~count_nxt;
         assign store_rst = '1;
      end else begin : g_plain
         assign count     = cnt_q;
         assign store_nxt = count_nxt;
         assign store_rst = '0;
      end
   endgenerate

   always_comb begin
      if (clr_i) begin
         count_nxt = '0;
      end else if (inc_i) begin
         count_nxt = count + AW'(1);
      end else begin
         count_nxt = count;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= store_rst;
      end else begin
         cnt_q <= store_nxt;
      end
   end

   assign cnt_o = count;

   assert_clr_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> cnt_o == '0);

endmodule

// File: rtl/wiper_lfsr.sv
module wiper_lfsr
   import wiper_pkg::*;
#(
   parameter lfsr_t SEED = 32'h5A3C_96E1,
   parameter lfsr_t TAPS = 32'h8020_0003,
   parameter perm_t PERM = default_perm()
) (
   input  logic  clk_i,
   input  logic  rst_ni,
   input  logic  load_i,
   input  lfsr_t seed_i,
   input  logic  step_i,
   output lfsr_t word_o
);

   generate
      if (SEED == '0) begin : g_bad_seed
         $error("wiper_lfsr: SEED must be nonzero");
      end
      if (!perm_valid(PERM)) begin : g_bad_perm
         $error("wiper_lfsr: PERM is not a permutation");
      end
   endgenerate

   lfsr_t state_q;
   lfsr_t load_val;

   assign load_val = (seed_i == '0) ? SEED : seed_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= SEED;
      end else if (load_i) begin
         state_q <= load_val;
      end else if (step_i) begin
         state_q <= lfsr_next(state_q, TAPS);
      end
   end

   generate
      for (genvar g = 0; g < LfsrW; g++) begin : g_perm
         assign word_o[g] = state_q[PERM[g*PermIdxW +: PermIdxW]];
      end
   endgenerate

   assert_state_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_q != '0);

   assert_step_moves_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && !load_i) |=> state_q != $past(state_q));

endmodule

// File: rtl/mem_wiper.sv
module mem_wiper
   import wiper_pkg::*;
#(
   parameter int    MEM_BYTES  = 4096,
   parameter int    NONCE_W    = 128,
   parameter int    SEED_OFS   = 64,
   parameter lfsr_t LFSR_SEED  = 32'h5A3C_96E1,
   parameter lfsr_t LFSR_TAPS  = 32'h8020_0003,
   parameter perm_t LFSR_PERM  = default_perm(),
   localparam int   WordCnt    = MEM_BYTES / 4,
   localparam int   AddrW      = $clog2(WordCnt)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               start_i,
   input  logic [NONCE_W-1:0] nonce_i,
   input  logic               bus_req_i,
   output logic               bus_gnt_o,
   output logic               ram_we_o,
   output logic [AddrW-1:0]   ram_addr_o,
   output logic [LfsrW-1:0]   ram_wdata_o,
   output logic               busy_o,
   output logic               done_o,
   output logic               err_o
);

   localparam logic [AddrW-1:0] LastAddr = AddrW'(WordCnt - 1);

   generate
      if ((MEM_BYTES % 4) != 0 || WordCnt < 2) begin : g_bad_size
         $error("mem_wiper: MEM_BYTES must be a multiple of 4 holding at least two words");
      end
      if (SEED_OFS + LfsrW > NONCE_W) begin : g_bad_ofs
         $error("mem_wiper: seed slice exceeds nonce width");
      end
   endgenerate

   wipe_state_e      state_q, state_d;
   logic             err_q;
   logic             start_ok;
   logic             running;
   logic             at_last;
   logic             mismatch;
   logic [AddrW-1:0] cnt_a, cnt_b;
   lfsr_t            seed_slice;
   logic             unused_nonce_bits;

   assign seed_slice        = nonce_i[SEED_OFS +: LfsrW];
   assign unused_nonce_bits = ^nonce_i;

   assign running  = (state_q == WipeRun);
   assign start_ok = start_i && ((state_q == WipeIdle) || (state_q == WipeDone));
   assign at_last  = (cnt_a == LastAddr);
   assign mismatch = (cnt_a != cnt_b);

   // Two address counters, the second one stored inverted.
   wiper_ctr #(.AW(AddrW), .INVERT(1'b0)) u_ctr_a (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (start_ok),
      .inc_i  (running && !at_last),
      .cnt_o  (cnt_a)
   );

   wiper_ctr #(.AW(AddrW), .INVERT(1'b1)) u_ctr_b (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (start_ok),
      .inc_i  (running && !at_last),
      .cnt_o  (cnt_b)
   );

   wiper_lfsr #(.SEED(LFSR_SEED), .TAPS(LFSR_TAPS), .PERM(LFSR_PERM)) u_lfsr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (start_ok),
      .seed_i (seed_slice),
      .step_i (running),
      .word_o (ram_wdata_o)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         WipeIdle, WipeDone: if (start_ok) state_d = WipeRun;
         WipeRun:            if (at_last)  state_d = WipeDone;
         default:            state_d = WipeErr;
      endcase
      if (mismatch) begin
         state_d = WipeErr;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= WipeIdle;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         err_q   <= err_q | mismatch;
      end
   end

   assign ram_we_o   = running;
   assign ram_addr_o = cnt_a;
   assign busy_o     = running;
   assign done_o     = (state_q == WipeDone);
   assign err_o      = err_q;
   assign bus_gnt_o  = bus_req_i && done_o && !err_q;

   assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_ok && !mismatch) |=> (busy_o && ram_addr_o == '0 && !done_o));

   assert_addr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (running && !at_last && !mismatch) |=> ram_addr_o == AddrW'($past(ram_addr_o) + 1'b1));

   assert_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (running && at_last && !mismatch) |=> (done_o && !ram_we_o));

   assert_gnt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_gnt_o |-> (done_o && !err_o && bus_req_i));

   assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |=> err_o);

   assert_no_we_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> (!ram_we_o && !done_o));

endmodule

// File: tb/mem_wiper_bench.sv
`timescale 1ns/1ps
module mem_wiper_bench;

   localparam int WORDS = 1024;
   localparam logic [31:0] RST_SEED = 32'h5A3C_96E1;
   localparam logic [31:0] TAPS     = 32'h8020_0003;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [127:0] nonce = '0;
   logic         bus_req = 1'b0;
   logic         bus_gnt, ram_we, busy, done, err;
   logic [9:0]   ram_addr;
   logic [31:0]  ram_wdata;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   mem_wiper u_mem_wiper (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .start_i     (start),
      .nonce_i     (nonce),
      .bus_req_i   (bus_req),
      .bus_gnt_o   (bus_gnt),
      .ram_we_o    (ram_we),
      .ram_addr_o  (ram_addr),
      .ram_wdata_o (ram_wdata),
      .busy_o      (busy),
      .done_o      (done),
      .err_o       (err)
   );

   function automatic logic [31:0] model_next(logic [31:0] s);
      return {1'b0, s[31:1]} ^ (s[0] ? TAPS : 32'h0);
   endfunction

   function automatic logic [31:0] model_perm(logic [31:0] s);
      logic [31:0] o;
      for (int i = 0; i < 32; i++) o[i] = s[(7 * i + 3) % 32];
      return o;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      bus_req = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!done && !err && !busy && !ram_we, "R1", "flags after reset",
            {60'd0, done, err, busy, ram_we}, 64'd0);
      check(!bus_gnt, "R7", "grant before first pass", 64'(bus_gnt), 64'd0);
   endtask

   // Runs a full pass; ign_at >= 0 pulses start with another nonce mid-walk (R8).
   task automatic t_walk(input logic [127:0] nce, input logic [31:0] seed,
                         input int ign_at, input string req);
      logic [31:0] s;
      int          bad;
      bad = 0;
      s = seed;
      @(negedge clk);
      nonce = nce;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy && !done && ram_addr == 10'd0, "R2", "pass begins",
            {32'd0, 20'd0, busy, done, ram_addr}, {32'd0, 20'd0, 1'b1, 1'b0, 10'd0});
      check(ram_wdata == model_perm(seed), req, "first word from seed",
            64'(ram_wdata), 64'(model_perm(seed)));
      for (int i = 0; i < WORDS; i++) begin
         if (!(ram_we && ram_addr == 10'(i) && ram_wdata == model_perm(s) && !bus_gnt)) begin
            if (bad == 0)
               check(1'b0, "R4", $sformatf("word %0d", i),
                     {21'd0, bus_gnt, ram_we, ram_addr, ram_wdata},
                     {22'd0, 1'b1, 10'(i), model_perm(s)});
            bad++;
         end
         if (i == ign_at) begin
            nonce = ~nce;
            start = 1'b1;
         end
         s = model_next(s);
         @(negedge clk);
         if (i == ign_at) begin
            start = 1'b0;
            check(ram_addr == 10'(i + 1) && ram_wdata == model_perm(s), "R8",
                  "start during pass ignored", {22'd0, ram_addr, ram_wdata},
                  {22'd0, 10'(i + 1), model_perm(s)});
         end
      end
      check(bad == 0, "R5", "all words match permuted sequence", 64'(bad), 64'd0);
      check(done && !ram_we && !busy && !err, "R6", "done after last word",
            {60'd0, done, ram_we, busy, err}, {60'd0, 4'b1000});
      check(bus_gnt, "R7", "grant after done", 64'(bus_gnt), 64'd1);
      @(negedge clk);
      check(done && !ram_we, "R6", "done holds", {62'd0, done, ram_we}, 64'd2);
   endtask

   task automatic t_error();
      logic [127:0] nce;
      nce = 128'h0;
      nce[95:64] = 32'hCAFE_0001;
      @(negedge clk);
      nonce = nce;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(!done, "R6", "done clears on new start", 64'(done), 64'd0);
      repeat (100) @(negedge clk);
      check(ram_we && ram_addr == 10'd100, "R2", "walk position before fault",
            {53'd0, ram_we, ram_addr}, {53'd0, 1'b1, 10'd100});
      force u_mem_wiper.u_ctr_b.cnt_q = 10'h000;
      @(negedge clk);
      release u_mem_wiper.u_ctr_b.cnt_q;
      check(err && !ram_we && !done && !bus_gnt, "R9", "fault stops writes",
            {60'd0, err, ram_we, done, bus_gnt}, {60'd0, 4'b1000});
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      check(err && !ram_we && !busy && !bus_gnt, "R9", "fault is terminal",
            {60'd0, err, ram_we, busy, bus_gnt}, {60'd0, 4'b1000});
   endtask

   initial begin
      logic [127:0] n1, n2, n0;
      n1 = '0; n1[95:64] = 32'h1234_5678; n1[31:0] = 32'hFFFF_FFFF;
      n2 = '0; n2[95:64] = 32'h0BAD_F00D; n2[127:96] = 32'h7;
      n0 = '1; n0[95:64] = 32'h0;
      t_reset();
      t_walk(n1, 32'h1234_5678, -1, "R3");
      t_walk(n2, 32'h0BAD_F00D, -1, "R10");
      t_walk(n1, 32'h1234_5678, 10, "R10");
      t_walk(n0, RST_SEED, -1, "R3");
      t_error();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule